// File: doc/BRIEF.md
# Reference Clock Selector with Failover

This block picks one of four external reference clocks, each nominally 1.544 MHz, to serve as the frequency reference for system timing. A fast local clock oversamples all four inputs. It measures the gap between rising edges on each input and qualifies an input only after a run of in-tolerance periods. Once it has locked onto a qualified input, the block keeps it until that input misses an edge or stops.

On a failure the block hunts round-robin, starting at the input after the failed one, and locks onto the first qualified input it reaches. While nothing is locked, the block is in master mode and drives a free-running square wave generated from the local clock. It relocks by itself, in slave mode, as soon as an input qualifies. The frequency-locking circuit that consumes `refOut` lies outside this block.

Top module: `refClockSelector`

## Requirements
- R1: During and after a synchronous active-high reset with no running inputs, `lockOut` is 0, `masterMode` is 1 and `selIdx` is 0.
- R2: An input becomes qualified only after GOOD_RUN consecutive rising-edge intervals, each of at most LATE_LIMIT local cycles. The first edge after reset, or after the input was declared dead, only starts the timing.
- R3: When LATE_LIMIT local cycles pass with no rising edge on an input, a miss is declared and that input loses its qualification. If it is the selected input, `lockOut` falls and `masterMode` rises in the cycle the miss is detected.
- R4: While locked, the selection does not change, even when other inputs qualify.
- R5: After a failure of input k, inputs are examined one per cycle in the order k+1, k+2, ... modulo 4. The first qualified input in that order is locked.
- R6: With no input locked, `masterMode` is 1, `lockOut` is 0 and `refOut` is a free-running square wave with a half period of FREE_HALF local cycles.
- R7: When an input qualifies while unlocked, the block locks onto it without intervention: `lockOut` is 1, `masterMode` is 0 and `refOut` follows that input through a two-flop synchronizer.
- R8: An input whose period exceeds LATE_LIMIT local cycles never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 4 | External reference inputs, bit i is input i |
| refOut | output | 1 | Selected reference, or free-running wave in master mode |
| selIdx | output | 2 | Index of the selected input |
| lockOut | output | 1 | 1 while locked on a qualified input |
| masterMode | output | 1 | 1 in free-running master mode, 0 in slave mode |

## Verification
A rising edge on an input reaches the monitor through two synchronizer flops and an edge register. A qualified input is locked at most four cycles later, so the scenario checks sample only after several hundred cycles, when every lock decision has settled. The same-cycle drop of the lock flag is checked by polling each falling clock edge after an input is stopped. At the sample where `lockOut` falls, `masterMode` must already be 1, and the fall must land within LATE_LIMIT plus a few synchronizer cycles of the stop. Output frequency is judged by counting `refOut` rising edges over fixed windows, with one edge of slack for phase.

// File: rtl/refSelPkg.sv
package refSelPkg;
  localparam int NUM_REF = 4;
  localparam int IDX_W = $clog2(NUM_REF);

  typedef struct packed {
    logic [IDX_W-1:0] selIdx;
    logic             useRef;
  } ctrlT;

  typedef enum logic {HUNT = 1'b0, LOCKED = 1'b1} selStateT;
endpackage

// File: rtl/refMonitor.sv
module refMonitor #(
  parameter int LATE_LIMIT = 12,
  parameter int GOOD_RUN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic edgeSeen,
  output logic missNow,
  output logic validNow
);
  localparam int GAP_W = $clog2(LATE_LIMIT + 1);
  localparam int GOOD_W = $clog2(GOOD_RUN + 1);

  logic [GAP_W-1:0] gapCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic dead;

  assign missNow = !dead && !edgeSeen && (gapCnt == GAP_W'(LATE_LIMIT - 1));
  assign validNow = !dead && !missNow && (goodCnt == GOOD_W'(GOOD_RUN));

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt <= '0;
      goodCnt <= '0;
      dead <= 1'b1;
    end else if (edgeSeen) begin
      gapCnt <= '0;
      dead <= 1'b0;
      if (dead) goodCnt <= '0;
      else if (goodCnt != GOOD_W'(GOOD_RUN)) goodCnt <= goodCnt + 1'b1;
    end else if (missNow) begin
      dead <= 1'b1;
      goodCnt <= '0;
    end else if (!dead) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end
endmodule

// File: rtl/refDatapath.sv
module refDatapath
  import refSelPkg::*;
#(
  parameter int LATE_LIMIT = 12,
  parameter int GOOD_RUN = 8,
  parameter int FREE_HALF = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REF-1:0] refIn,
  input  ctrlT               ctrl,
  output logic [NUM_REF-1:0] missVec,
  output logic [NUM_REF-1:0] validVec,
  output logic               refOut
);
  localparam int FREE_W = $clog2(FREE_HALF + 1);

  logic [NUM_REF-1:0] sync1, sync2, prevS;
  logic [NUM_REF-1:0] edgeVec;
  logic [FREE_W-1:0] freeCnt;
  logic freeRef;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      prevS <= '0;
    end else begin
      sync1 <= refIn;
      sync2 <= sync1;
      prevS <= sync2;
    end
  end

  assign edgeVec = sync2 & ~prevS;

  for (genvar i = 0; i < NUM_REF; i++) begin : gMon
    refMonitor #(.LATE_LIMIT(LATE_LIMIT), .GOOD_RUN(GOOD_RUN)) mon (
      .clk(clk), .rst(rst), .edgeSeen(edgeVec[i]),
      .missNow(missVec[i]), .validNow(validVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freeCnt <= '0;
      freeRef <= 1'b0;
    end else if (freeCnt == FREE_W'(FREE_HALF - 1)) begin
      freeCnt <= '0;
      freeRef <= ~freeRef;
    end else begin
      freeCnt <= freeCnt + 1'b1;
    end
  end

  assign refOut = ctrl.useRef ? sync2[ctrl.selIdx] : freeRef;
endmodule

// File: rtl/refControl.sv
module refControl
  import refSelPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REF-1:0] missVec,
  input  logic [NUM_REF-1:0] validVec,
  output ctrlT               ctrl,
  output logic               lockOut,
  output logic               masterMode
);
  selStateT state;
  logic [IDX_W-1:0] selReg, scanPtr;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(NUM_REF - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HUNT;
      selReg <= '0;
      scanPtr <= '0;
    end else if (state == HUNT) begin
      if (validVec[scanPtr]) begin
        state <= LOCKED;
        selReg <= scanPtr;
      end else begin
        scanPtr <= nextIdx(scanPtr);
      end
    end else if (missVec[selReg]) begin
      state <= HUNT;
      scanPtr <= nextIdx(selReg);
    end
  end

  assign lockOut = (state == LOCKED) && !missVec[selReg];
  assign masterMode = !lockOut;
  assign ctrl.selIdx = selReg;
  assign ctrl.useRef = lockOut;
endmodule

// File: rtl/refClockSelector.sv
module refClockSelector
  import refSelPkg::*;
#(
  parameter int LATE_LIMIT = 12,
  parameter int GOOD_RUN = 8,
  parameter int FREE_HALF = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   refIn,
  output logic         refOut,
  output logic [1:0]   selIdx,
  output logic         lockOut,
  output logic         masterMode
);
  ctrlT ctrl;
  logic [NUM_REF-1:0] missVec, validVec;

  refDatapath #(.LATE_LIMIT(LATE_LIMIT), .GOOD_RUN(GOOD_RUN), .FREE_HALF(FREE_HALF)) dp (
    .clk(clk), .rst(rst), .refIn(refIn), .ctrl(ctrl),
    .missVec(missVec), .validVec(validVec), .refOut(refOut)
  );

  refControl cu (
    .clk(clk), .rst(rst), .missVec(missVec), .validVec(validVec),
    .ctrl(ctrl), .lockOut(lockOut), .masterMode(masterMode)
  );

  assign selIdx = ctrl.selIdx;
endmodule

// File: rtl/refSelChecker.sv
module refSelChecker (
  input logic       clk,
  input logic       rst,
  input logic       lockOut,
  input logic [1:0] selIdx,
  input logic [3:0] missVec,
  input logic [3:0] validVec
);
  logic [3:0] validPrev;
  always_ff @(posedge clk) begin
    if (rst) validPrev <= '0;
    else validPrev <= validVec;
  end

  assert_hold_sel_R4: assert property (@(posedge clk) disable iff (rst)
    lockOut |=> (!lockOut || $stable(selIdx)));

  assert_drop_on_miss_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(lockOut) |-> missVec[selIdx]);

  assert_lock_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lockOut) |-> validPrev[selIdx]);

  assert_locked_valid_R7: assert property (@(posedge clk) disable iff (rst)
    lockOut |-> validVec[selIdx]);
endmodule

bind refClockSelector refSelChecker chk (
  .clk(clk), .rst(rst), .lockOut(lockOut), .selIdx(selIdx),
  .missVec(missVec), .validVec(validVec)
);

// File: tb/refClockSelector_test.sv
module refClockSelector_test;
  localparam int CLK_PERIOD = 10;
  localparam int LATE = 12;
  localparam int GOOD = 8;
  localparam int FHALF = 4;
  localparam int NSCEN = 7;

  // entry: half periods of inputs 3..0 (0 = stopped), expected lock, expected index
  localparam logic [18:0] SCEN [NSCEN] = '{
    {4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 2'd0},
    {4'd0, 4'd4, 4'd0, 4'd0, 1'b1, 2'd2},
    {4'd4, 4'd4, 4'd0, 4'd4, 1'b1, 2'd2},
    {4'd4, 4'd0, 4'd0, 4'd4, 1'b1, 2'd3},
    {4'd0, 4'd0, 4'd0, 4'd4, 1'b1, 2'd0},
    {4'd0, 4'd0, 4'd10, 4'd0, 1'b0, 2'd0},
    {4'd0, 4'd0, 4'd4, 4'd0, 1'b1, 2'd1}
  };
  localparam string TAG [NSCEN] = '{"R6", "R7", "R4", "R5", "R5", "R8", "R7"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] refIn = '0;
  logic refOut, lockOut, masterMode;
  logic [1:0] selIdx;
  logic [3:0] halfP [4];
  int ph [4];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  refClockSelector #(.LATE_LIMIT(LATE), .GOOD_RUN(GOOD), .FREE_HALF(FHALF)) uut (
    .clk(clk), .rst(rst), .refIn(refIn), .refOut(refOut),
    .selIdx(selIdx), .lockOut(lockOut), .masterMode(masterMode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (halfP[i] == 0) begin
        refIn[i] <= 1'b0;
        ph[i] <= 0;
      end else if (ph[i] >= int'(halfP[i]) - 1) begin
        refIn[i] <= ~refIn[i];
        ph[i] <= 0;
      end else begin
        ph[i] <= ph[i] + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, actual cycles %0d expected under 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic setHalves(input logic [15:0] h);
    for (int i = 0; i < 4; i++) halfP[i] = h[i*4 +: 4];
  endtask

  task automatic countEdges(input int cycles, output int n);
    logic prev;
    n = 0;
    prev = refOut;
    repeat (cycles) begin
      @(negedge clk);
      if (!prev && refOut) n++;
      prev = refOut;
    end
  endtask

  initial begin
    int n;
    for (int i = 0; i < 4; i++) begin
      halfP[i] = '0;
      ph[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 lock in reset", int'(lockOut), 0);
    chk("R1 master in reset", int'(masterMode), 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 lock after reset", int'(lockOut), 0);
    chk("R1 master after reset", int'(masterMode), 1);
    chk("R1 index after reset", int'(selIdx), 0);

    for (int s = 0; s < NSCEN; s++) begin
      setHalves(SCEN[s][18:3]);
      repeat (300) @(negedge clk);
      chk(TAG[s], int'(lockOut), int'(SCEN[s][2]));
      chk(TAG[s], int'(masterMode), int'(!SCEN[s][2]));
      if (SCEN[s][2]) chk(TAG[s], int'(selIdx), int'(SCEN[s][1:0]));
    end

    // R7: refOut follows the selected input (period 10 local cycles)
    halfP[1] = 4'd5;
    repeat (50) @(negedge clk);
    countEdges(100, n);
    chkRange("R7 follow selected input edges", n, 9, 11);
    chk("R7 still locked", int'(lockOut), 1);

    // R6: free-running wave once everything stops
    halfP[1] = 4'd0;
    repeat (60) @(negedge clk);
    chk("R6 master with no input", int'(masterMode), 1);
    countEdges(80, n);
    chkRange("R6 free-run edges", n, 9, 11);

    // R2: qualification needs GOOD_RUN intervals
    halfP[3] = 4'd4;
    repeat (40) @(negedge clk);
    chk("R2 not yet qualified", int'(lockOut), 0);
    repeat (160) @(negedge clk);
    chk("R2 qualified lock", int'(lockOut), 1);
    chk("R2 qualified index", int'(selIdx), 3);

    // R3: same-cycle drop of lock and rise of master after a stop
    halfP[3] = 4'd0;
    repeat (2) @(negedge clk);
    chk("R3 lock held before timeout", int'(lockOut), 1);
    n = 2;
    while (lockOut && n < 40) begin
      @(negedge clk);
      n++;
    end
    chkRange("R3 drop delay after stop", n, LATE - 8, LATE + 6);
    chk("R3 master in drop cycle", int'(masterMode), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule